// File: doc/BRIEF.md
# Protected Mode Guard

This block owns the processor's protected-mode flag and inspects every executed command and every data access against it. The decoder hands it one-cycle flags for the command now executing: the enter-protected command, the group of privileged I/O and interrupt-mask commands, the software interrupt and a bad-operand indication. The load/store path hands it an address with a valid strobe. Two bound registers give the window of memory that unprivileged code may touch.

While protection is on, a privileged command is refused and traps, and an access outside the window traps. The trap is a one-cycle request on a fixed interrupt line, which is a parameter. A bad operand traps whether or not protection is on. The cause of the first trap is held in a small status register until software reads it.

The software interrupt is the only way out of protected mode, because it hands control to a trusted handler. Executing the instructions themselves is left to the core.

Top module: `prot_guard`

## Requirements
- R1: After reset `prot_on` is 0, `viol_req` is 0 and `stat_cause` is 0 (no cause).
- R2: A valid enter-protected command while protection is off sets `prot_on` on the next cycle and raises no violation.
- R3: A valid software interrupt clears `prot_on` on the next cycle. It wins over any other command in the same cycle. An access in that cycle is still checked under the old mode.
- R4: While `prot_on` is 1, a valid privileged command raises `viol_req` for one cycle on the next cycle, with cause 2 (privileged command). Privileged commands are the I/O and interrupt-mask group and the enter-protected command itself. Such a command is refused: `priv_grant` stays 0 and the mode is unchanged.
- R5: While `prot_on` is 0, a valid privileged command drives `priv_grant` high in the same cycle and raises no violation.
- R6: While `prot_on` is 1, an access at address A traps with cause 3 (region) on the next cycle unless base <= A < limit. The comparison uses unsigned values, so A = limit and A = base-1 trap, while A = base and A = limit-1 do not.
- R7: While `prot_on` is 0, no access traps, whatever its address.
- R8: A valid bad-operand flag traps with cause 1 (bad operand) on the next cycle in either mode.
- R9: Once `stat_cause` is non-zero it keeps its value until a cycle with `stat_rd` high. Later causes do not overwrite it. On a read the register takes the cause of that same cycle, or 0 if there is none.
- R10: When several causes arise in one cycle, the recorded cause is chosen by priority: bad operand (1) first, then privileged command (2), then region (3).
- R11: `viol_line` always equals the parameter `VIOL_LINE` (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is executing this cycle |
| cmd_set_prot | input | 1 | Command is enter-protected |
| cmd_priv_io | input | 1 | Command is in the privileged I/O / interrupt-mask group |
| cmd_swint | input | 1 | Command is a software interrupt |
| cmd_bad_opnd | input | 1 | Command carries a bad operand |
| acc_valid | input | 1 | A data access is made this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| rgn_base | input | ADDR_W | Lowest permitted address (inclusive) |
| rgn_limit | input | ADDR_W | End of permitted window (exclusive) |
| stat_rd | input | 1 | Status read; clears the held cause |
| prot_on | output | 1 | Protected mode is active |
| priv_grant | output | 1 | Privileged command may take effect this cycle |
| viol_req | output | 1 | One-cycle violation interrupt request |
| viol_line | output | LINE_W | Interrupt line number of the request |
| stat_cause | output | 2 | Held cause: 0 none, 1 bad operand, 2 privileged, 3 region |

## Verification
`priv_grant` is combinational and is checked in the stimulus cycle, one time unit after the inputs change. `prot_on`, `viol_req` and `stat_cause` each pass through a single register. They are due on the edge that follows the stimulus.

The driver works out those three values from its own model once that edge has passed, and queues them. The monitor compares them on the following falling edge, so every expected item is matched against exactly one clock of design state.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_BAD_OPND = 2'd1,
    CAUSE_PRIV_CMD = 2'd2,
    CAUSE_REGION   = 2'd3
  } cause_e;

  // Priority encoder for simultaneous causes (R10)
  function automatic cause_e pick_cause(input logic bad, input logic priv, input logic rgn);
    if (bad)       return CAUSE_BAD_OPND;
    else if (priv) return CAUSE_PRIV_CMD;
    else if (rgn)  return CAUSE_REGION;
    else           return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/prot_mode_reg.sv
module prot_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_set_prot,
  input  logic cmd_swint,
  output logic prot_on
);

  logic enter_evt;
  logic leave_evt;

  assign leave_evt = cmd_valid & cmd_swint;
  assign enter_evt = cmd_valid & cmd_set_prot & ~prot_on & ~cmd_swint;

  always_ff @(posedge clk) begin
    if (!rst_n)         prot_on <= 1'b0;
    else if (leave_evt) prot_on <= 1'b0;
    else if (enter_evt) prot_on <= 1'b1;
  end

  assert_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_swint) |=> !prot_on);

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_set_prot && !cmd_swint) |=> prot_on);

  assert_spm_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !(cmd_valid && cmd_swint)) |=> prot_on);

endmodule

// File: rtl/region_check.sv
module region_check #(
  parameter int ADDR_W = 32
) (
  input  logic              prot_on,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] rgn_base,
  input  logic [ADDR_W-1:0] rgn_limit,
  output logic              region_viol
);

  // Half-open unsigned window [lo, hi)
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  logic addr_ok;

  assign addr_ok     = in_window(acc_addr, rgn_base, rgn_limit);
  assign region_viol = prot_on & acc_valid & ~addr_ok;

  always_comb begin
    assert_window_R6: assert (!(acc_valid && prot_on && (acc_addr < rgn_base)) || region_viol);
  end

endmodule

// File: rtl/viol_status.sv
module viol_status
  import prot_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_e evt_cause,
  input  logic   stat_rd,
  output logic   viol_req,
  output cause_e stat_cause
);

  logic evt_any;
  logic slot_open;

  assign evt_any   = (evt_cause != CAUSE_NONE);
  assign slot_open = stat_rd | (stat_cause == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_req   <= 1'b0;
      stat_cause <= CAUSE_NONE;
    end else begin
      viol_req <= evt_any;
      if (slot_open) stat_cause <= evt_cause;
    end
  end

  assert_hold_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_cause != CAUSE_NONE && !stat_rd) |=> $stable(stat_cause));

  assert_req_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_req |-> (stat_cause != CAUSE_NONE || $past(stat_rd)));

endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 4,
  parameter int VIOL_LINE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_set_prot,
  input  logic              cmd_priv_io,
  input  logic              cmd_swint,
  input  logic              cmd_bad_opnd,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] rgn_base,
  input  logic [ADDR_W-1:0] rgn_limit,
  input  logic              stat_rd,
  output logic              prot_on,
  output logic              priv_grant,
  output logic              viol_req,
  output logic [LINE_W-1:0] viol_line,
  output logic [1:0]        stat_cause
);

  localparam logic [LINE_W-1:0] LINE_ID = LINE_W'(VIOL_LINE);

  logic   priv_cmd;
  logic   priv_trap;
  logic   bad_trap;
  logic   region_viol;
  cause_e evt_cause;
  cause_e held_cause;

  assign priv_cmd   = cmd_valid & (cmd_set_prot | cmd_priv_io);
  assign priv_trap  = priv_cmd & prot_on;
  assign bad_trap   = cmd_valid & cmd_bad_opnd;
  assign priv_grant = priv_cmd & ~prot_on;
  assign evt_cause  = pick_cause(bad_trap, priv_trap, region_viol);
  assign viol_line  = LINE_ID;
  assign stat_cause = held_cause;

  prot_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_set_prot (cmd_set_prot),
    .cmd_swint    (cmd_swint),
    .prot_on      (prot_on)
  );

  region_check #(.ADDR_W(ADDR_W)) u_region (
    .prot_on     (prot_on),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .rgn_base    (rgn_base),
    .rgn_limit   (rgn_limit),
    .region_viol (region_viol)
  );

  viol_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_cause  (evt_cause),
    .stat_rd    (stat_rd),
    .viol_req   (viol_req),
    .stat_cause (held_cause)
  );

  assert_priv_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_set_prot || cmd_priv_io) && prot_on) |=> viol_req);

  assert_bad_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bad_opnd) |=> viol_req);

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_on && !(cmd_valid && cmd_bad_opnd)) |=> !viol_req);

  assert_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && acc_valid && acc_addr >= rgn_limit) |=> viol_req);

  always_comb begin
    assert_line_R11: assert (viol_line == LINE_ID);
  end

endmodule

// File: tb/prot_guard_test.sv
module prot_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_set_prot = 0, cmd_priv_io = 0, cmd_swint = 0, cmd_bad_opnd = 0;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = '0, rgn_base = '0, rgn_limit = '0;
  logic        stat_rd = 0;
  logic        prot_on, priv_grant, viol_req;
  logic [3:0]  viol_line;
  logic [1:0]  stat_cause;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic       prot;
    logic       req;
    logic [1:0] cause;
  } exp_t;

  exp_t sb_q[$];
  logic       m_prot = 0;
  logic [1:0] m_stat = 0;

  always #2.5 clk = ~clk;

  prot_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_set_prot(cmd_set_prot),
    .cmd_priv_io(cmd_priv_io), .cmd_swint(cmd_swint), .cmd_bad_opnd(cmd_bad_opnd),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .rgn_base(rgn_base), .rgn_limit(rgn_limit),
    .stat_rd(stat_rd), .prot_on(prot_on), .priv_grant(priv_grant), .viol_req(viol_req),
    .viol_line(viol_line), .stat_cause(stat_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one command/access per call, grant checked in-cycle, registered results queued
  task automatic step(input logic s, input logic p, input logic w, input logic b,
                      input logic a, input logic [31:0] ad, input logic rd, input string tag);
    logic [1:0] c;
    logic rgn, prv, exp_grant;
    @(negedge clk);
    cmd_set_prot = s; cmd_priv_io = p; cmd_swint = w; cmd_bad_opnd = b;
    cmd_valid = s | p | w | b; acc_valid = a; acc_addr = ad; stat_rd = rd;
    #1;
    exp_grant = (s | p) & ~m_prot;
    check({tag, " grant R5/R4"}, {31'd0, priv_grant}, {31'd0, exp_grant});
    prv = (s | p) & m_prot;
    rgn = m_prot & a & ((ad < rgn_base) | (ad >= rgn_limit));
    if (b)        c = 2'd1;
    else if (prv) c = 2'd2;
    else if (rgn) c = 2'd3;
    else          c = 2'd0;
    @(posedge clk);
    if (rd || m_stat == 2'd0) m_stat = c;
    if (w)               m_prot = 1'b0;
    else if (s && !m_prot) m_prot = 1'b1;
    sb_q.push_back('{prot: m_prot, req: (c != 2'd0), cause: m_stat});
  endtask

  // Monitor: compare registered outputs on the falling edge after the update
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check("prot_on R2/R3", {31'd0, prot_on}, {31'd0, e.prot});
      check("viol_req R4/R6/R8", {31'd0, viol_req}, {31'd0, e.req});
      check("stat_cause R9/R10", {30'd0, stat_cause}, {30'd0, e.cause});
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rgn_base = 32'h0000_1000;
    rgn_limit = 32'h0000_2000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, R11 line number
    check("reset prot R1", {31'd0, prot_on}, 32'd0);
    check("reset req R1", {31'd0, viol_req}, 32'd0);
    check("reset cause R1", {30'd0, stat_cause}, 32'd0);
    check("line R11", {28'd0, viol_line}, 32'd1);
    // R5 privileged command allowed when off; R7 accesses unchecked when off
    step(0, 1, 0, 0, 0, 0, 0, "io off");
    step(0, 0, 0, 0, 1, 32'hFFFF_0000, 0, "acc off R7");
    // R2 enter protected mode
    step(1, 0, 0, 0, 0, 0, 0, "enter R2");
    // R6 window boundaries
    step(0, 0, 0, 0, 1, 32'h0000_1000, 0, "base R6");
    step(0, 0, 0, 0, 1, 32'h0000_1FFF, 0, "limit-1 R6");
    step(0, 0, 0, 0, 1, 32'h0000_2000, 0, "limit R6");
    // R4 privileged trap; R9 first cause kept
    step(0, 1, 0, 0, 0, 0, 0, "io trap R4 R9");
    step(0, 0, 0, 0, 0, 0, 1, "read R9");
    step(0, 0, 0, 0, 1, 32'h0000_0FFF, 0, "base-1 R6");
    step(0, 0, 0, 0, 0, 0, 1, "read2 R9");
    // R4 enter-protected itself is privileged
    step(1, 0, 0, 0, 0, 0, 0, "spm trap R4");
    step(0, 0, 0, 0, 0, 0, 1, "read3 R9");
    step(0, 0, 0, 1, 0, 0, 0, "bad R8");
    // R10 priorities, with read reloading the same cycle (R9)
    step(0, 1, 0, 1, 1, 32'h0, 1, "all R10");
    step(0, 0, 0, 0, 0, 0, 1, "read4 R9");
    step(0, 1, 0, 0, 1, 32'h0, 0, "priv>rgn R10");
    step(0, 0, 0, 0, 0, 0, 1, "read5 R9");
    step(0, 0, 0, 0, 1, 32'hFFFF_FFF0, 0, "high addr R6");
    step(0, 0, 0, 0, 0, 0, 1, "read6 R9");
    // R3 leave on software interrupt, access same cycle still checked
    step(0, 0, 1, 0, 1, 32'h0000_3000, 0, "swint R3");
    step(0, 0, 0, 0, 0, 0, 1, "read7 R9");
    step(0, 0, 0, 0, 1, 32'h0000_3000, 0, "acc after R7");
    step(0, 0, 0, 1, 0, 0, 0, "bad off R8");
    step(1, 0, 1, 0, 0, 0, 1, "swint wins R3");
    @(negedge clk);
    cmd_valid = 0; cmd_set_prot = 0; cmd_priv_io = 0; cmd_swint = 0; cmd_bad_opnd = 0;
    acc_valid = 0; stat_rd = 0;
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule